// File: doc/BRIEF.md
# Timer-Triggered Pulse Output Port

This block drives eight output pins from two data registers that software fills through a small register port. The pins change only when a timer event strobe arrives, never at the moment of the bus write. Pin edges therefore follow the timer, and software has a whole timer period to stage the next pattern. The pins are split into a low group of four and a high group of four. Each group has its own trigger source, picked from four timer event strobes.

The low group always loads bits 3..0 of data register 0. The high group always loads bits 7..6 of data register 1. A mode bit decides whether its middle pair takes bits 5..4 of data register 0 or bits 5..4 of data register 1. The three lowest pins can each be ANDed with a PWM waveform, selected from three timer PWM inputs. A polarity bit inverts every pin.

A three-bit port-select field switches the whole port off when it is zero. Each group also has an enable flag. For the low group, an external cut input clears that flag asynchronously. For the high group, a timer stop event does the same. A cleared flag forces its pins to the inactive level at once.

Top module: `rtpo_port`

## Requirements
- R1: After reset all four registers read 0 and `pulse_o` is 8'h00.
- R2: A register write does not change `pulse_o`. The output latches change only in a cycle in which the selected trigger strobe is high.
- R3: The low group (pins 3..0) loads data register 0 bits 3..0 on the clock edge at which trigger input `trig_i[sel_lo]` is high. `sel_lo` is TRIG bits 1..0. Strobes on the other trigger inputs leave the low group unchanged.
- R4: The high group loads on the edge at which `trig_i[sel_hi]` is high. `sel_hi` is TRIG bits 3..2. Pins 5..4 take data register 0 bits 5..4 when CTRL bit 3 (mode) is 0. They take data register 1 bits 5..4 when mode is 1.
- R5: On a high-group load, pins 7..6 take data register 1 bits 7..6.
- R6: When a data-register write and a trigger occur in the same cycle, the latch takes the value the register held before the write.
- R7: When CTRL bits 2..0 (port select) are 000, every pin equals the polarity bit.
- R8: TRIG bits 6..4 enable PWM on pins 2..0 (bit 4 for pin 0). On an enabled pin the latched value is ANDed with the PWM source `pwm_i[k]`, where k is CTRL bits 5..4. Code 3 passes the latched value through unchanged. The PWM input reaches the pin without a clock delay.
- R9: TRIG bit 7 (polarity) inverts every pin. An inactive pin shows the polarity value.
- R10: CTRL bit 7 enables the low group and CTRL bit 6 enables the high group. While the enable is clear, the group's pins are inactive. While `cut_i` is high, bit 7 is held clear asynchronously. While `stop_i` is high, bit 6 is held clear asynchronously. Software sets the bits again by writing CTRL.
- R11: Addresses 0 (CTRL), 1 (TRIG), 2 (data 0) and 3 (data 1) read back the last written value through `rdata_o`, combinationally from `addr_i`. The enable bits show their current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| trig_i | input | 4 | Timer event strobes, one cycle each |
| pwm_i | input | 3 | Timer PWM waveforms |
| cut_i | input | 1 | Asynchronous low-group shut-off |
| stop_i | input | 1 | Asynchronous high-group shut-off (timer stop event) |
| pulse_o | output | 8 | Pulse output pins |

## Verification
A trigger strobe that is high at a rising edge shows on the pins one edge later. Writes, read data, PWM, polarity and enable changes are visible in the same cycle. The driver changes inputs only on falling edges. After each stimulus it queues the expected value, and the monitor checks it 5 ns after the next rising edge. That point lies after every register update from that edge and before the next input change. The cut path is also checked 1 ns after `cut_i` rises, with no clock edge in between, to show that the clear is asynchronous.

// File: rtl/rtpo_pkg.sv
package rtpo_pkg;
  localparam int DW      = 8;
  localparam int AW      = 2;
  localparam int N_TRIG  = 4;
  localparam int N_PWM   = 3;
  localparam int SEL_W   = 2;
  localparam int GRP_W   = 4;
  localparam int N_GRP   = DW / GRP_W;

  typedef enum logic [AW-1:0] {
    A_CTRL = 2'd0,
    A_TRIG = 2'd1,
    A_DAT0 = 2'd2,
    A_DAT1 = 2'd3
  } addr_e;

  typedef struct packed {
    logic             en_lo;
    logic             en_hi;
    logic [SEL_W-1:0] pwm_sel;
    logic             mode;
    logic [2:0]       port_sel;
  } ctrl_t;

  typedef struct packed {
    logic             pol;
    logic [N_PWM-1:0] pwm_en;
    logic [SEL_W-1:0] sel_hi;
    logic [SEL_W-1:0] sel_lo;
  } trig_t;
endpackage

// File: rtl/rtpo_regs.sv
module rtpo_regs
  import rtpo_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cut_i,
  input  logic          stop_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output ctrl_t         ctrl_o,
  output trig_t         trig_o,
  output logic [DW-1:0] dat0_o,
  output logic [DW-1:0] dat1_o
);
  localparam int CLO_W = DW - 2;

  logic [CLO_W-1:0] ctrl_lo_q;
  trig_t            trig_q;
  logic [DW-1:0]    dat0_q, dat1_q;
  logic             en_lo_q, en_hi_q;
  logic             clr_lo_n, clr_hi_n;
  logic             wr_ctrl;
  ctrl_t            wr_view;

  assign wr_ctrl  = wr_en_i && (addr_i == A_CTRL);
  assign wr_view  = ctrl_t'(wdata_i);
  assign clr_lo_n = rst_ni & ~cut_i;
  assign clr_hi_n = rst_ni & ~stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_lo_q <= '0;
      trig_q    <= '0;
      dat0_q    <= '0;
      dat1_q    <= '0;
    end else if (wr_en_i) begin
      unique case (addr_e'(addr_i))
        A_CTRL: ctrl_lo_q <= wdata_i[CLO_W-1:0];
        A_TRIG: trig_q    <= trig_t'(wdata_i);
        A_DAT0: dat0_q    <= wdata_i;
        A_DAT1: dat1_q    <= wdata_i;
        default: ;
      endcase
    end
  end

  // group enables: cleared asynchronously by shut-off events
  always_ff @(posedge clk_i or negedge clr_lo_n) begin
    if (!clr_lo_n)    en_lo_q <= 1'b0;
    else if (wr_ctrl) en_lo_q <= wr_view.en_lo;
  end

  always_ff @(posedge clk_i or negedge clr_hi_n) begin
    if (!clr_hi_n)    en_hi_q <= 1'b0;
    else if (wr_ctrl) en_hi_q <= wr_view.en_hi;
  end

  assign ctrl_o = ctrl_t'({en_lo_q, en_hi_q, ctrl_lo_q});
  assign trig_o = trig_q;
  assign dat0_o = dat0_q;
  assign dat1_o = dat1_q;

  always_comb begin
    unique case (addr_e'(addr_i))
      A_CTRL:  rdata_o = ctrl_o;
      A_TRIG:  rdata_o = trig_q;
      A_DAT0:  rdata_o = dat0_q;
      A_DAT1:  rdata_o = dat1_q;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rtpo_pick.sv
module rtpo_pick #(
  parameter int   N    = 4,
  parameter int   W    = 2,
  parameter logic FILL = 1'b0
) (
  input  logic [N-1:0] src_i,
  input  logic [W-1:0] sel_i,
  output logic         pick_o
);
  localparam int M = 1 << W;

  logic [M-1:0] full;

  generate
    if (M > N) begin : g_pad
      assign full = {{(M-N){FILL}}, src_i};
    end else begin : g_exact
      assign full = src_i;
    end
  endgenerate

  assign pick_o = full[sel_i];
endmodule

// File: rtl/rtpo_lane.sv
module rtpo_lane #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/rtpo_shape.sv
module rtpo_shape #(
  parameter int DW = 8,
  parameter int NP = 3
) (
  input  logic [DW-1:0] q_i,
  input  logic [DW-1:0] act_i,
  input  logic [NP-1:0] pwm_en_i,
  input  logic          pwm_i,
  input  logic          pol_i,
  output logic [DW-1:0] pin_o
);
  generate
    for (genvar i = 0; i < DW; i++) begin : g_bit
      logic lvl;
      if (i < NP) begin : g_mod
        assign lvl = q_i[i] & (~pwm_en_i[i] | pwm_i);
      end else begin : g_plain
        assign lvl = q_i[i];
      end
      assign pin_o[i] = (lvl & act_i[i]) ^ pol_i;
    end
  endgenerate
endmodule

// File: rtl/rtpo_port.sv
module rtpo_port
  import rtpo_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic [N_PWM-1:0]  pwm_i,
  input  logic              cut_i,
  input  logic              stop_i,
  output logic [DW-1:0]     pulse_o
);
  ctrl_t                        ctrl;
  trig_t                        trig;
  logic [DW-1:0]                dat0, dat1;
  logic [N_GRP-1:0]             load;
  logic [N_GRP-1:0][SEL_W-1:0]  grp_sel;
  logic [N_GRP-1:0][GRP_W-1:0]  grp_d, grp_q;
  logic [DW-1:0]                out_q, act;
  logic                         port_on, pwm_sel_lvl;

  rtpo_regs u_regs (
    .clk_i, .rst_ni, .cut_i, .stop_i, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .ctrl_o(ctrl), .trig_o(trig), .dat0_o(dat0), .dat1_o(dat1)
  );

  assign grp_sel[0] = trig.sel_lo;
  assign grp_sel[1] = trig.sel_hi;
  assign grp_d[0]   = dat0[GRP_W-1:0];
  assign grp_d[1]   = {dat1[7:6], ctrl.mode ? dat1[5:4] : dat0[5:4]};

  generate
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
      rtpo_pick #(.N(N_TRIG), .W(SEL_W), .FILL(1'b0)) u_trig_pick (
        .src_i(trig_i), .sel_i(grp_sel[g]), .pick_o(load[g])
      );
      rtpo_lane #(.W(GRP_W)) u_lane (
        .clk_i, .rst_ni, .load_i(load[g]), .d_i(grp_d[g]), .q_o(grp_q[g])
      );
    end
  endgenerate

  assign out_q = grp_q;

  // code past the last source selects constant high: modulation bypassed
  rtpo_pick #(.N(N_PWM), .W(SEL_W), .FILL(1'b1)) u_pwm_pick (
    .src_i(pwm_i), .sel_i(ctrl.pwm_sel), .pick_o(pwm_sel_lvl)
  );

  assign port_on = |ctrl.port_sel;
  assign act     = {{GRP_W{port_on & ctrl.en_hi}}, {GRP_W{port_on & ctrl.en_lo}}};

  rtpo_shape #(.DW(DW), .NP(N_PWM)) u_shape (
    .q_i(out_q), .act_i(act), .pwm_en_i(trig.pwm_en), .pwm_i(pwm_sel_lvl),
    .pol_i(trig.pol), .pin_o(pulse_o)
  );
endmodule

// File: rtl/rtpo_port_chk.sv
module rtpo_port_chk
  import rtpo_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cut_i,
  input logic             stop_i,
  input logic [DW-1:0]    pulse_o,
  input logic [DW-1:0]    out_q,
  input logic [N_GRP-1:0] load,
  input logic [DW-1:0]    dat0,
  input logic [DW-1:0]    dat1,
  input ctrl_t            ctrl,
  input trig_t            trig
);
  assert_hold_lo_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load[0] |=> $stable(out_q[3:0]));
  assert_hold_hi_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load[1] |=> $stable(out_q[7:4]));
  assert_lo_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load[0] |=> out_q[3:0] == $past(dat0[3:0]));
  assert_mid_mode_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load[1] |=> out_q[5:4] == ($past(ctrl.mode) ? $past(dat1[5:4]) : $past(dat0[5:4])));
  assert_hi_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load[1] |=> out_q[7:6] == $past(dat1[7:6]));
  assert_port_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.port_sel == 3'b000) |-> (pulse_o == {DW{trig.pol}}));
  assert_cut_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cut_i |-> !ctrl.en_lo);
  assert_stop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |-> !ctrl.en_hi);
endmodule

bind rtpo_port rtpo_port_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cut_i(cut_i), .stop_i(stop_i),
  .pulse_o(pulse_o), .out_q(out_q), .load(load), .dat0(dat0), .dat1(dat1),
  .ctrl(ctrl), .trig(trig)
);

// File: tb/rtpo_port_bench.sv
`timescale 1ns/1ps
module rtpo_port_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [3:0] trig_i = '0;
  logic [2:0] pwm_i = '0;
  logic       cut_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [7:0] pulse_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit         is_rd;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  // bench model of programmed state
  logic [7:0] m_ctrl = '0, m_trg = '0, m_d0 = '0, m_d1 = '0, m_out = '0;

  always #10 clk_i = ~clk_i;

  rtpo_port u_rtpo_port (.*);

  function automatic logic [7:0] model_pin();
    logic [7:0] r;
    logic act_lo, act_hi, pw, v;
    act_lo = (m_ctrl[2:0] != 3'b000) && m_ctrl[7];
    act_hi = (m_ctrl[2:0] != 3'b000) && m_ctrl[6];
    pw = (m_ctrl[5:4] == 2'd3) ? 1'b1 : pwm_i[m_ctrl[5:4]];
    for (int i = 0; i < 8; i++) begin
      v = m_out[i];
      if (i < 3 && m_trg[4+i]) v = v & pw;
      v = v & ((i < 4) ? act_lo : act_hi);
      r[i] = v ^ m_trg[7];
    end
    return r;
  endfunction

  task automatic model_fire(input logic [3:0] mask);
    if (mask[m_trg[1:0]]) m_out[3:0] = m_d0[3:0];
    if (mask[m_trg[3:2]]) m_out[7:4] = {m_d1[7:6], m_ctrl[3] ? m_d1[5:4] : m_d0[5:4]};
  endtask

  task automatic model_wr(input logic [1:0] a, input logic [7:0] d);
    case (a)
      2'd0: m_ctrl = d;
      2'd1: m_trg  = d;
      2'd2: m_d0   = d;
      default: m_d1 = d;
    endcase
  endtask

  task automatic push(input bit rd, input logic [7:0] exp, input string tag);
    item_t it;
    it.is_rd = rd; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk_i);
  endtask

  task automatic exp_pin(input string tag);
    push(1'b0, model_pin(), tag);
  endtask

  task automatic exp_rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    addr_i = a;
    push(1'b1, exp, tag);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    model_wr(a, d);
  endtask

  task automatic fire(input logic [3:0] mask);
    @(negedge clk_i);
    trig_i = mask;
    @(negedge clk_i);
    trig_i = '0;
    model_fire(mask);
  endtask

  task automatic wr_and_fire(input logic [1:0] a, input logic [7:0] d, input logic [3:0] mask);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d; trig_i = mask;
    @(negedge clk_i);
    wr_en_i = 1'b0; trig_i = '0;
    model_fire(mask);
    model_wr(a, d);
  endtask

  task automatic direct(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare mid high phase after each rising edge
  initial begin
    item_t it;
    forever begin
      @(posedge clk_i);
      #5;
      while (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        direct(it.is_rd ? rdata_o : pulse_o, it.exp, it.tag);
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    exp_pin("R1 pins after reset");
    exp_rd(2'd0, 8'h00, "R1 ctrl reset");
    exp_rd(2'd1, 8'h00, "R1 trig reset");
    exp_rd(2'd2, 8'h00, "R1 dat0 reset");
    exp_rd(2'd3, 8'h00, "R1 dat1 reset");

    // R11 readback
    bus_wr(2'd0, 8'hC1);
    bus_wr(2'd1, 8'h04);
    exp_rd(2'd0, 8'hC1, "R11 ctrl readback");
    exp_rd(2'd1, 8'h04, "R11 trig readback");

    // R2 writes alone do not move pins
    bus_wr(2'd2, 8'hA5);
    bus_wr(2'd3, 8'h3C);
    exp_rd(2'd2, 8'hA5, "R11 dat0 readback");
    exp_rd(2'd3, 8'h3C, "R11 dat1 readback");
    direct(pulse_o, 8'h00, "R2 pins unchanged by write");

    // R4/R5 high group only (source 1), mode 0
    fire(4'b0010);
    exp_pin("R4 R5 high group mode0");
    direct(pulse_o[3:0], 4'h0, "R3 low group ignores other source");

    // R3 low group
    fire(4'b0001);
    exp_pin("R3 low group load");
    fire(4'b1000);
    exp_pin("R3 unselected source ignored");

    // R4 mode 1
    bus_wr(2'd0, 8'hC9);
    exp_pin("R2 mode write no pin change");
    fire(4'b0010);
    exp_pin("R4 mid pair from dat1");

    // R6 collision
    wr_and_fire(2'd2, 8'h0F, 4'b0001);
    exp_pin("R6 same-cycle keeps old value");
    fire(4'b0001);
    exp_pin("R6 new value on next trigger");

    // R8 PWM
    bus_wr(2'd1, 8'h74);
    pwm_i = 3'b000;
    exp_pin("R8 pwm src0 low gates");
    pwm_i = 3'b001;
    exp_pin("R8 pwm src0 high passes");
    bus_wr(2'd0, 8'hE9);
    exp_pin("R8 pwm src2 low gates");
    pwm_i = 3'b100;
    exp_pin("R8 pwm src2 high passes");
    pwm_i = 3'b000;
    bus_wr(2'd0, 8'hF9);
    exp_pin("R8 code3 bypass");

    // R9 polarity
    bus_wr(2'd1, 8'hF4);
    exp_pin("R9 inverted pins");

    // R7 port off
    bus_wr(2'd0, 8'hF8);
    exp_pin("R7 port off shows polarity");
    bus_wr(2'd1, 8'h74);
    exp_pin("R7 port off no polarity");
    bus_wr(2'd0, 8'hC9);
    exp_pin("R7 port back on");

    // R10 cut and stop
    @(negedge clk_i);
    cut_i = 1'b1;
    m_ctrl[7] = 1'b0;
    #1;
    direct(pulse_o, model_pin(), "R10 cut async");
    @(negedge clk_i);
    cut_i = 1'b0;
    exp_pin("R10 low group off after cut");
    exp_rd(2'd0, 8'h49, "R10 ctrl bit7 cleared");
    @(negedge clk_i);
    stop_i = 1'b1;
    m_ctrl[6] = 1'b0;
    @(negedge clk_i);
    stop_i = 1'b0;
    exp_pin("R10 high group off after stop");
    exp_rd(2'd0, 8'h09, "R10 ctrl bit6 cleared");
    bus_wr(2'd0, 8'hC9);
    exp_pin("R10 re-enabled by write");

    repeat (2) @(negedge clk_i);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule